// File: doc/BRIEF.md
# Register File with Pointer Unit

This block holds the working registers of a small 8-bit processor core: 32 registers of 8 bits with two combinational read ports and one clocked write port, so that an arithmetic operation reads both operands and writes its result in the same cycle. The top six registers also form three 16-bit address pointers. A pointer unit picks one of them for a data-space access, forms the effective address, and writes the updated pointer back into the file after a post-increment or pre-decrement access.

The effective address is decoded into three regions. The lowest 32 addresses map onto the register file itself, so a data-space load or store can reach any register as if it were memory. The next 64 addresses are flagged as the I/O region and all higher addresses as the SRAM region. For these two regions only the region code and the address leave the block. The Z pointer is always presented on a separate output for program-memory constant lookups.

Each access is a single-cycle transaction, and the addressing mode selects one of four paths: plain, post-increment, pre-decrement or displacement. All four paths are decided within the cycle in which `mem_req` is high.

Top module: `regfile_ptr`

## Requirements
- R1: An active-low asynchronous reset clears all 32 registers to 0x00.
- R2: Both read ports return the addressed register combinationally. A write with `wr_en` high takes effect at the next rising clock edge. A read of the register being written in the same cycle returns the old value.
- R3: Pointer X is registers 26 (low byte) and 27 (high byte), Y is 28/29 and Z is 30/31. `ptr_sel` selects 0=X, 1=Y, 2=Z, and the value 3 also selects Z. `addr_mode` 0 (plain) puts the pointer value on `mem_addr` and leaves the pointer unchanged.
- R4: `addr_mode` 1 (post-increment) puts the pointer value on `mem_addr`. After the clock edge the pointer holds that value plus 1, and a carry passes from the low byte into the high byte.
- R5: `addr_mode` 2 (pre-decrement) puts the pointer value minus 1 on `mem_addr`, and after the edge the pointer holds that value. The subtraction wraps modulo 2^16.
- R6: `addr_mode` 3 (displacement) with Y or Z puts the pointer plus the unsigned 6-bit `disp` on `mem_addr` and leaves the pointer unchanged. With X, `disp` is ignored and the access acts as plain.
- R7: `const_addr` always equals the current Z pointer.
- R8: `mem_region` is 0 for addresses 0x0000 to 0x001F, 1 for 0x0020 to 0x005F and 2 for 0x0060 and above.
- R9: In region 0, `ds_rdata` is the register numbered `mem_addr[4:0]`, and `ds_we` stores `ds_wdata` into that register at the edge. In the other regions `ds_rdata` is 0x00 and `ds_we` changes no register.
- R10: When writes collide on one register at an edge, a pointer update takes priority over a data-space store, and a data-space store takes priority over a `wr_en` write.
- R11: With `mem_req` low, no pointer changes through the pointer unit and `ds_we` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_sel | input | 5 | Read port A register number |
| rd_a_data | output | 8 | Read port A data |
| rd_b_sel | input | 5 | Read port B register number |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Result write enable |
| wr_sel | input | 5 | Result register number |
| wr_data | input | 8 | Result data |
| mem_req | input | 1 | Data-space access this cycle |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 or 3 Z |
| addr_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| disp | input | 6 | Unsigned displacement |
| ds_we | input | 1 | Data-space store enable |
| ds_wdata | input | 8 | Data-space store data |
| ds_rdata | output | 8 | Data-space load data from the file |
| mem_addr | output | 16 | Effective data-space address |
| mem_region | output | 2 | Region: 0 file, 1 I/O, 2 SRAM |
| const_addr | output | 16 | Z pointer for constant lookups |

## Verification
The properties assume that every control input is driven to a known value in every cycle after reset. The stability properties for the displacement and idle cases also assume that no `wr_en` or `ds_we` write lands on the observed pointer in that cycle. For this reason the displacement property is qualified by both enables being low. The stimulus changes inputs only on falling edges and sets the pointers through separate `wr_en` cycles, never during an access. Collisions occur only in the dedicated priority scenario, where the outcome is checked through the read ports.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
    typedef enum logic [1:0] {
        AM_PLAIN   = 2'b00,
        AM_POSTINC = 2'b01,
        AM_PREDEC  = 2'b10,
        AM_DISP    = 2'b11
    } amode_t;

    typedef enum logic [1:0] {
        RG_FILE = 2'b00,
        RG_IO   = 2'b01,
        RG_SRAM = 2'b10
    } region_t;
endpackage

// File: rtl/rfp_storage.sv
module rfp_storage #(
    parameter int W     = 8,
    parameter int NREG  = 32,
    parameter int SEL_W = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    rd_a_sel,
    output logic [W-1:0]        rd_a_data,
    input  logic [SEL_W-1:0]    rd_b_sel,
    output logic [W-1:0]        rd_b_data,
    input  logic                alu_en,
    input  logic [SEL_W-1:0]    alu_sel,
    input  logic [W-1:0]        alu_data,
    input  logic                ds_en,
    input  logic [SEL_W-1:0]    ds_sel,
    input  logic [W-1:0]        ds_data,
    input  logic                pu_en,
    input  logic [SEL_W-1:0]    pu_lo_sel,
    input  logic [SEL_W-1:0]    pu_hi_sel,
    input  logic [2*W-1:0]      pu_val,
    output logic [NREG*W-1:0]   file_flat
);
    logic [NREG-1:0][W-1:0] mem;

    // priority: pointer update, then data-space store, then result write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (pu_en && pu_lo_sel == SEL_W'(i))
                    mem[i] <= pu_val[W-1:0];
                else if (pu_en && pu_hi_sel == SEL_W'(i))
                    mem[i] <= pu_val[2*W-1:W];
                else if (ds_en && ds_sel == SEL_W'(i))
                    mem[i] <= ds_data;
                else if (alu_en && alu_sel == SEL_W'(i))
                    mem[i] <= alu_data;
            end
        end
    end

    assign rd_a_data = mem[rd_a_sel];
    assign rd_b_data = mem[rd_b_sel];
    assign file_flat = mem;
endmodule

// File: rtl/rfp_ptr_unit.sv
module rfp_ptr_unit import rfp_pkg::*; #(
    parameter int AW = 16,
    parameter int QW = 6
) (
    input  logic          req,
    input  amode_t        mode,
    input  logic          sel_is_x,
    input  logic [AW-1:0] ptr_val,
    input  logic [QW-1:0] disp,
    output logic [AW-1:0] eff_addr,
    output logic          upd_en,
    output logic [AW-1:0] upd_val
);
    always_comb begin
        eff_addr = ptr_val;
        upd_en   = 1'b0;
        upd_val  = ptr_val;
        unique case (mode)
            AM_PLAIN: begin
            end
            AM_POSTINC: begin
                upd_en  = req;
                upd_val = ptr_val + AW'(1);
            end
            AM_PREDEC: begin
                eff_addr = ptr_val - AW'(1);
                upd_en   = req;
                upd_val  = ptr_val - AW'(1);
            end
            AM_DISP: begin
                if (!sel_is_x) eff_addr = ptr_val + AW'(disp);
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/rfp_addr_decode.sv
module rfp_addr_decode import rfp_pkg::*; #(
    parameter int AW       = 16,
    parameter int NREG     = 32,
    parameter int IO_COUNT = 64
) (
    input  logic [AW-1:0] addr,
    output region_t       region
);
    localparam int IO_END = NREG + IO_COUNT;

    always_comb begin
        if (addr < AW'(NREG))
            region = RG_FILE;
        else if (addr < AW'(IO_END))
            region = RG_IO;
        else
            region = RG_SRAM;
    end
endmodule

// File: rtl/regfile_ptr.sv
module regfile_ptr import rfp_pkg::*; #(
    parameter int W        = 8,
    parameter int NREG     = 32,
    parameter int QW       = 6,
    parameter int IO_COUNT = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREG)-1:0]  rd_a_sel,
    output logic [W-1:0]             rd_a_data,
    input  logic [$clog2(NREG)-1:0]  rd_b_sel,
    output logic [W-1:0]             rd_b_data,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_sel,
    input  logic [W-1:0]             wr_data,
    input  logic                     mem_req,
    input  logic [1:0]               ptr_sel,
    input  logic [1:0]               addr_mode,
    input  logic [QW-1:0]            disp,
    input  logic                     ds_we,
    input  logic [W-1:0]             ds_wdata,
    output logic [W-1:0]             ds_rdata,
    output logic [2*W-1:0]           mem_addr,
    output logic [1:0]               mem_region,
    output logic [2*W-1:0]           const_addr
);
    localparam int SEL_W    = $clog2(NREG);
    localparam int AW       = 2 * W;
    localparam int NPTR     = 3;
    localparam int PTR_BASE = NREG - 2 * NPTR;

    logic [NREG*W-1:0] file_flat;
    logic [AW-1:0]     ptr_pair [NPTR];
    logic [AW-1:0]     ptr_val_x, ptr_val_y, ptr_val_z;
    logic [1:0]        ptr_idx;
    logic [AW-1:0]     sel_ptr;
    logic [SEL_W-1:0]  pu_lo_sel, pu_hi_sel;
    logic              pu_en;
    logic [AW-1:0]     pu_val;
    region_t           region;
    logic              file_hit;
    logic              ds_file_we;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        assign ptr_pair[g] = file_flat[(PTR_BASE + 2*g)*W +: AW];
    end

    assign ptr_val_x  = ptr_pair[0];
    assign ptr_val_y  = ptr_pair[1];
    assign ptr_val_z  = ptr_pair[2];
    assign const_addr = ptr_val_z;

    assign ptr_idx   = (ptr_sel == 2'b11) ? 2'd2 : ptr_sel;
    assign sel_ptr   = ptr_pair[ptr_idx];
    assign pu_lo_sel = SEL_W'(PTR_BASE + 2 * int'(ptr_idx));
    assign pu_hi_sel = pu_lo_sel | SEL_W'(1);

    rfp_ptr_unit #(.AW(AW), .QW(QW)) u_ptr (
        .req      (mem_req),
        .mode     (amode_t'(addr_mode)),
        .sel_is_x (ptr_idx == 2'd0),
        .ptr_val  (sel_ptr),
        .disp     (disp),
        .eff_addr (mem_addr),
        .upd_en   (pu_en),
        .upd_val  (pu_val)
    );

    rfp_addr_decode #(.AW(AW), .NREG(NREG), .IO_COUNT(IO_COUNT)) u_dec (
        .addr   (mem_addr),
        .region (region)
    );

    assign mem_region = region;
    assign file_hit   = (region == RG_FILE);
    assign ds_file_we = mem_req && ds_we && file_hit;
    assign ds_rdata   = file_hit ? file_flat[mem_addr[SEL_W-1:0]*W +: W] : '0;

    rfp_storage #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_sel  (rd_a_sel),
        .rd_a_data (rd_a_data),
        .rd_b_sel  (rd_b_sel),
        .rd_b_data (rd_b_data),
        .alu_en    (wr_en),
        .alu_sel   (wr_sel),
        .alu_data  (wr_data),
        .ds_en     (ds_file_we),
        .ds_sel    (mem_addr[SEL_W-1:0]),
        .ds_data   (ds_wdata),
        .pu_en     (pu_en),
        .pu_lo_sel (pu_lo_sel),
        .pu_hi_sel (pu_hi_sel),
        .pu_val    (pu_val),
        .file_flat (file_flat)
    );
endmodule

// File: rtl/rfp_checker.sv
module rfp_checker #(
    parameter int W     = 8,
    parameter int NREG  = 32,
    parameter int SEL_W = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [W-1:0]     wr_data,
    input logic [SEL_W-1:0] rd_a_sel,
    input logic [W-1:0]     rd_a_data,
    input logic             mem_req,
    input logic [1:0]       ptr_sel,
    input logic [1:0]       addr_mode,
    input logic             ds_we,
    input logic [2*W-1:0]   mem_addr,
    input logic [1:0]       mem_region,
    input logic [2*W-1:0]   ptr_x,
    input logic [2*W-1:0]   ptr_y,
    input logic [2*W-1:0]   ptr_z
);
    p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !mem_req |=> (rd_a_sel != $past(wr_sel) || rd_a_data == $past(wr_data)));

    p_postinc_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && addr_mode == 2'b01 && ptr_sel == 2'b10 |=> ptr_z == $past(ptr_z) + 16'd1);

    p_predec_y_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && addr_mode == 2'b10 && ptr_sel == 2'b01 |-> mem_addr == ptr_y - 16'd1);

    p_disp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && addr_mode == 2'b11 && ptr_sel == 2'b01 && !wr_en && !ds_we |=> ptr_y == $past(ptr_y));

    p_file_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr < 16'(NREG) |-> mem_region == 2'b00);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req && !wr_en |=> $stable(ptr_x));
endmodule

bind regfile_ptr rfp_checker #(.W(W), .NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_a_sel   (rd_a_sel),
    .rd_a_data  (rd_a_data),
    .mem_req    (mem_req),
    .ptr_sel    (ptr_sel),
    .addr_mode  (addr_mode),
    .ds_we      (ds_we),
    .mem_addr   (mem_addr),
    .mem_region (mem_region),
    .ptr_x      (ptr_val_x),
    .ptr_y      (ptr_val_y),
    .ptr_z      (ptr_val_z)
);

// File: tb/regfile_ptr_bench.sv
module regfile_ptr_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_sel, rd_b_sel, wr_sel;
    logic [7:0]  rd_a_data, rd_b_data, wr_data, ds_wdata, ds_rdata;
    logic        wr_en, mem_req, ds_we;
    logic [1:0]  ptr_sel, addr_mode, mem_region;
    logic [5:0]  disp;
    logic [15:0] mem_addr, const_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    regfile_ptr u_regfile_ptr (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mem_req(mem_req), .ptr_sel(ptr_sel), .addr_mode(addr_mode), .disp(disp),
        .ds_we(ds_we), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
        .mem_addr(mem_addr), .mem_region(mem_region), .const_addr(const_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en = 0; mem_req = 0; ds_we = 0; ptr_sel = 0; addr_mode = 0; disp = 0;
        wr_sel = 0; wr_data = 0; ds_wdata = 0;
    endtask

    task automatic put(input logic [4:0] s, input logic [7:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        cyc();
        wr_en = 0;
    endtask

    task automatic peek(input logic [4:0] s, output logic [7:0] d);
        rd_a_sel = s;
        #1 d = rd_a_data;
    endtask

    task automatic access(input logic [1:0] p, input logic [1:0] m, input logic [5:0] q);
        mem_req = 1; ptr_sel = p; addr_mode = m; disp = q;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(0, v);  chk("R1", v, 8'h00);
        peek(31, v); chk("R1", v, 8'h00);
        peek(17, v); chk("R1", v, 8'h00);
    endtask

    task automatic t_alu();
        logic [7:0] v;
        put(5, 8'h3C); put(6, 8'hA5);
        rd_a_sel = 5; rd_b_sel = 6;
        #1 chk("R2", rd_a_data, 8'h3C); chk("R2", rd_b_data, 8'hA5);
        wr_en = 1; wr_sel = 5; wr_data = 8'h77;
        #1 chk("R2", rd_a_data, 8'h3C);
        cyc(); wr_en = 0;
        peek(5, v); chk("R2", v, 8'h77);
    endtask

    task automatic t_plain();
        logic [7:0] v;
        put(26, 8'h34); put(27, 8'h12);
        access(0, 0, 0);
        #1 chk("R3", mem_addr, 16'h1234); chk("R8", mem_region, 2'd2);
        cyc(); quiet();
        peek(26, v); chk("R3", v, 8'h34);
        peek(27, v); chk("R3", v, 8'h12);
    endtask

    task automatic t_postinc();
        logic [7:0] v;
        put(30, 8'hFF); put(31, 8'h00);
        access(2, 1, 0);
        #1 chk("R4", mem_addr, 16'h00FF);
        cyc(); quiet();
        peek(30, v); chk("R4", v, 8'h00);
        peek(31, v); chk("R4", v, 8'h01);
        chk("R7", const_addr, 16'h0100);
    endtask

    task automatic t_predec();
        logic [7:0] v;
        put(28, 8'h00); put(29, 8'h00);
        access(1, 2, 0);
        #1 chk("R5", mem_addr, 16'hFFFF);
        cyc(); quiet();
        peek(28, v); chk("R5", v, 8'hFF);
        peek(29, v); chk("R5", v, 8'hFF);
    endtask

    task automatic t_disp();
        logic [7:0] v;
        put(28, 8'h40); put(29, 8'h00);
        access(1, 3, 6'd63);
        #1 chk("R6", mem_addr, 16'h007F);
        cyc(); quiet();
        peek(28, v); chk("R6", v, 8'h40);
        peek(29, v); chk("R6", v, 8'h00);
        access(0, 3, 6'd5);
        #1 chk("R6", mem_addr, 16'h1234);
        cyc(); quiet();
        peek(26, v); chk("R6", v, 8'h34);
    endtask

    task automatic t_region();
        logic [7:0] v;
        put(16, 8'h5A); put(21, 8'h11);
        put(30, 8'h10); put(31, 8'h00);
        access(3, 0, 0);
        #1 chk("R8", mem_region, 2'd0); chk("R9", ds_rdata, 8'h5A);
        ds_we = 1; ds_wdata = 8'hC3;
        cyc(); quiet();
        peek(16, v); chk("R9", v, 8'hC3);
        put(30, 8'h35);
        access(2, 0, 0); ds_we = 1; ds_wdata = 8'h99;
        #1 chk("R8", mem_region, 2'd1); chk("R9", ds_rdata, 8'h00);
        cyc(); quiet();
        peek(21, v); chk("R9", v, 8'h11);
        put(30, 8'h5F);
        access(2, 0, 0);
        #1 chk("R8", mem_region, 2'd1);
        cyc(); quiet();
        put(30, 8'h60);
        access(2, 0, 0);
        #1 chk("R8", mem_region, 2'd2);
        cyc(); quiet();
    endtask

    task automatic t_conflict();
        logic [7:0] v;
        put(30, 8'h00); put(31, 8'h02);
        access(2, 1, 0);
        wr_en = 1; wr_sel = 30; wr_data = 8'hEE;
        cyc(); quiet();
        peek(30, v); chk("R10", v, 8'h01);
        peek(31, v); chk("R10", v, 8'h02);
        put(30, 8'h07); put(31, 8'h00);
        access(2, 0, 0); ds_we = 1; ds_wdata = 8'h44;
        wr_en = 1; wr_sel = 7; wr_data = 8'h55;
        cyc(); quiet();
        peek(7, v); chk("R10", v, 8'h44);
    endtask

    task automatic t_idle();
        logic [7:0] v;
        ptr_sel = 2; addr_mode = 1; ds_we = 1; ds_wdata = 8'hAB;
        cyc(); quiet();
        peek(30, v); chk("R11", v, 8'h07);
        peek(7, v);  chk("R11", v, 8'h44);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rd_a_sel = 0; rd_b_sel = 0;
        quiet();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_alu();
        t_plain();
        t_postinc();
        t_predec();
        t_disp();
        t_region();
        t_conflict();
        t_idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule